// File: doc/BRIEF.md
# Variable-Length Word Serializer

This block turns a parallel word into a single-wire bit stream whose length is chosen per word at run time, anywhere from 6 to 16 bits. A one-cycle start strobe captures the word and its length into internal registers. From the next cycle on, the block emits one bit per clock, least-significant bit first, and stops after exactly the programmed number of bits. While idle, the serial line rests at logic 0.

A busy flag covers the whole transfer. A one-cycle done pulse marks the cycle in which the final bit is on the line. A new start may arrive at any time, including mid-word. It abandons the current transfer, and the new word's first bit appears in the following cycle. The source may change the parallel bus and the length input freely once start has been sampled, because both are held internally.

Top module: `pser_top`

## Requirements
- R1: While the synchronous active-high reset is sampled high, and in the cycle after it, ser_out, busy and done are all 0, even if a transfer was in progress.
- R2: When start is sampled high at a rising edge, then in the following cycle busy is 1 and ser_out equals bit 0 of the word_in value captured at that edge.
- R3: Bits go out least-significant first. In the k-th cycle after the start edge (k = 0, 1, ...), ser_out equals bit k of the captured word.
- R4: len_in is an unsigned binary bit count. For an effective length L, exactly L bits are emitted. In the cycle after the last bit, busy returns to 0.
- R5: done is high for exactly one cycle per completed word: the cycle in which bit L-1 is on ser_out. It is never high while busy is low.
- R6: A len_in below 6 (values 0 to 5) gives L = 6. A len_in above 16 (values 17 to 31) gives L = 16. The value is clamped when it is captured.
- R7: Changing word_in or len_in while a word is being shifted has no effect on the bits emitted or on the transfer length.
- R8: A start sampled during a transfer abandons the current word. The next cycle shows bit 0 of the new word, busy stays 1, and no done pulse is produced for the abandoned word.
- R9: Whenever busy is 0, ser_out is 0.
- R10: A start sampled in the cycle that carries the final bit still shows done in that cycle. The new word begins in the next cycle with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load strobe: capture word and length, begin a transfer |
| word_in | input | 16 | Parallel word; bit 0 is sent first |
| len_in | input | 5 | Requested bit count, unsigned, clamped to 6..16 |
| ser_out | output | 1 | Serial data, low when idle |
| busy | output | 1 | High while a word is on the line |
| done | output | 1 | One-cycle pulse with the final bit |

## Verification
Two functions can coincide in one cycle: completing a word, with its final bit and done pulse, and loading the next one. The bench provokes this by raising start on exactly the cycle it expects the final bit. It then judges that done is still seen in that cycle and that bit 0 of the new word follows with no idle cycle in between. A mid-word restart is checked in the same way, by confirming that no done pulse belongs to the abandoned word.

// File: rtl/pser_pkg.sv
package pser_pkg;

    localparam int DEF_WORD_W  = 16;
    localparam int DEF_MIN_LEN = 6;

    // Clamp a requested count into [lo, hi].
    function automatic int clamp_count(input int raw, input int lo, input int hi);
        if (raw < lo) return lo;
        if (raw > hi) return hi;
        return raw;
    endfunction

    // Transfer-tracking state carried by the bit counter.
    typedef struct packed {
        logic       active;
        logic [4:0] count;
        logic [4:0] last_idx;
    } track_t;

endpackage

// File: rtl/pser_len_clamp.sv
module pser_len_clamp #(
    parameter int WORD_W  = pser_pkg::DEF_WORD_W,
    parameter int MIN_LEN = pser_pkg::DEF_MIN_LEN,
    parameter int LEN_W   = $clog2(WORD_W + 1)
) (
    input  logic [LEN_W-1:0] len_req,
    output logic [LEN_W-1:0] len_eff
);
    always_comb begin
        len_eff = LEN_W'(pser_pkg::clamp_count(int'(len_req), MIN_LEN, WORD_W));
    end
endmodule

// File: rtl/pser_bit_counter.sv
module pser_bit_counter #(
    parameter int WORD_W = pser_pkg::DEF_WORD_W,
    parameter int LEN_W  = $clog2(WORD_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len_eff,
    output logic             active,
    output logic             last
);
    logic             act_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] end_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            cnt_q <= '0;
            end_q <= '0;
        end else if (load) begin
            act_q <= 1'b1;
            cnt_q <= '0;
            end_q <= len_eff - LEN_W'(1);
        end else if (act_q) begin
            if (last) begin
                act_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
        end
    end

    assign active = act_q;
    assign last   = act_q && (cnt_q == end_q);
endmodule

// File: rtl/pser_shifter.sv
module pser_shifter #(
    parameter int WORD_W = pser_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] word,
    output logic              lsb
);
    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)        sh_q <= '0;
        else if (load)  sh_q <= word;
        else if (shift) sh_q <= {1'b0, sh_q[WORD_W-1:1]};
    end

    assign lsb = sh_q[0];
endmodule

// File: rtl/pser_top.sv
module pser_top #(
    parameter int WORD_W  = pser_pkg::DEF_WORD_W,
    parameter int MIN_LEN = pser_pkg::DEF_MIN_LEN,
    localparam int LEN_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] word_in,
    input  logic [LEN_W-1:0]  len_in,
    output logic              ser_out,
    output logic              busy,
    output logic              done
);
    logic [LEN_W-1:0] len_eff;
    logic             active;
    logic             last;
    logic             lsb;

    pser_len_clamp #(.WORD_W(WORD_W), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_clamp (
        .len_req (len_in),
        .len_eff (len_eff)
    );

    pser_bit_counter #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (start),
        .len_eff (len_eff),
        .active  (active),
        .last    (last)
    );

    pser_shifter #(.WORD_W(WORD_W)) u_sh (
        .clk   (clk),
        .rst   (rst),
        .load  (start),
        .shift (active),
        .word  (word_in),
        .lsb   (lsb)
    );

    assign ser_out = active & lsb;
    assign busy    = active;
    assign done    = last;
endmodule

// File: rtl/pser_chk.sv
module pser_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic ser_out,
    input logic busy,
    input logic done
);
    // R9
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ser_out);

    // R5
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R4
    hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && !start) |=> busy);

    // R4
    end_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !busy);

    // R8
    restart_nodone_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !done);
endmodule

bind pser_top pser_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ser_out (ser_out),
    .busy    (busy),
    .done    (done)
);

// File: tb/pser_top_test.sv
module pser_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] word_in = '0;
    logic [4:0]  len_in = '0;
    logic        ser_out, busy, done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pser_top uut (
        .clk(clk), .rst(rst), .start(start), .word_in(word_in),
        .len_in(len_in), .ser_out(ser_out), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff_len(input int l);
        if (l < 6) return 6;
        if (l > 16) return 16;
        return l;
    endfunction

    // Present a word at a falling edge; return in the cycle that shows bit 0.
    // Inputs are scrambled afterwards (R7).
    task automatic launch(input logic [15:0] w, input logic [4:0] l);
        start   = 1'b1;
        word_in = w;
        len_in  = l;
        @(negedge clk);
        start   = 1'b0;
        word_in = 16'($urandom);
        len_in  = 5'($urandom);
    endtask

    // Check n bits of a word of effective length L; stays in the cycle of bit n-1.
    task automatic observe(input logic [15:0] w, input int L, input int n);
        for (int k = 0; k < n; k++) begin
            chk("R3 bit", {15'b0, ser_out}, {15'b0, w[k]});
            chk("R2 busy", {15'b0, busy}, 16'd1);
            chk("R5 done", {15'b0, done}, {15'b0, (k == L-1)});
            if (k % 3 == 1) begin
                word_in = ~word_in;
                len_in  = 5'($urandom);
            end
            if (k < n-1) @(negedge clk);
        end
    endtask

    task automatic idle_check(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            chk("R4 busy off", {15'b0, busy}, 16'd0);
            chk("R9 idle low", {15'b0, ser_out}, 16'd0);
            chk("R5 no done", {15'b0, done}, 16'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 ser_out", {15'b0, ser_out}, 16'd0);
        chk("R1 busy", {15'b0, busy}, 16'd0);
        chk("R1 done", {15'b0, done}, 16'd0);
        rst = 1'b0;
        @(negedge clk);

        // R4 R6 sweep over every len_in code with several word patterns
        for (int l = 0; l < 32; l++) begin
            for (int p = 0; p < 4; p++) begin
                logic [15:0] w;
                int L;
                L = eff_len(l);
                case (p)
                    0: w = 16'($urandom);
                    1: w = 16'hFFFF;
                    2: w = 16'h5555 ^ 16'(l);
                    default: w = 16'(1) << (L - 1);
                endcase
                launch(w, 5'(l));
                observe(w, L, L);
                idle_check(2);
            end
        end

        // R8 restart mid-word
        begin
            logic [15:0] a, b;
            a = 16'hC3A5;
            b = 16'h0F1E;
            launch(a, 5'd10);
            observe(a, 10, 4);
            launch(b, 5'd7);
            observe(b, 7, 7);
            idle_check(2);
        end

        // R10 start coinciding with the final bit
        begin
            logic [15:0] a, b;
            a = 16'h002D;
            b = 16'h1B7;
            launch(a, 5'd6);
            observe(a, 6, 6);
            launch(b, 5'd9);
            observe(b, 9, 9);
            idle_check(2);
            a = 16'hBEEF;
            launch(a, 5'd16);
            observe(a, 16, 16);
            launch(16'hFFFF, 5'd3);
            observe(16'hFFFF, 6, 6);
            idle_check(1);
        end

        // R1 reset during a transfer
        launch(16'hFFFF, 5'd12);
        observe(16'hFFFF, 12, 3);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid busy", {15'b0, busy}, 16'd0);
        chk("R1 mid ser_out", {15'b0, ser_out}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after busy", {15'b0, busy}, 16'd0);
        chk("R1 after done", {15'b0, done}, 16'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule